// File: doc/BRIEF.md
# Oscillator Trim Controller

This block keeps a free-running internal oscillator close to its target frequency. A 16-bit counter clocked by the oscillator is reloaded on every edge of a slow reference sync. When the reference period and the oscillator period have the intended ratio, the sync arrives just as the counter has run down to zero. Any distance from zero is the frequency error. On each sync event the block captures that error and its sign. It sorts the event into an OK, warning or error band around a programmable limit and, with auto-trim on, nudges a 6-bit trim code by one step toward the target.

Software uses a small word-wide register port. Through it, software enables counting and auto-trim, sets the reload and limit, chooses one of three sync inputs, the active edge and a power-of-two prescaler, and can fire a sync by writing a control bit. It also reads back the status and clears flags. The sync inputs are treated as already synchronous to `clk`. One interrupt line combines the enabled flags.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, trim is 32, reload is 0xBB7F, limit is 0x22, prescaler code is 0, source code is 2, polarity is rising, counting and auto-trim are off, all flags are 0 and `irq` is 0. Register map: address 0 is control (bit0 count enable, bit1 auto-trim, bit2 software sync, bits 6:3 interrupt enables for OK/warning/error/expected, bits 13:8 trim). Address 1 is configuration (bits 15:0 reload, 23:16 limit, 26:24 prescaler, 29:28 source, 31 polarity). Address 2 is status (bits 6:0 = `flags`, bit 15 direction, bits 31:16 capture). Address 3 is write-one-to-clear (bit0 OK, bit1 warning, bit2 error group, bit3 expected).
- R2: After a sync event, the counter counts down from the reload value. For events G cycles apart, the next event captures |G − (reload+1)| into `err_cap`. `err_dir` is 0 when G > reload+1 (oscillator fast) and 1 otherwise, including zero error.
- R3: `flags[3]` (expected sync) is set in the cycle the counter reaches zero while counting down. After that the counter counts upward.
- R4: At a sync event, with captured value E and limit L: E < L sets `flags[0]` (OK); L ≤ E < 3L sets `flags[1]` (warning); E ≥ 3L sets `flags[4]` (sync error). `flags[2]` is the OR of `flags[4]`, `flags[5]` and `flags[6]`.
- R5: In the warning band with auto-trim on, trim rises by 1 when direction is 1 and falls by 1 when direction is 0. Trim does not move in the OK or error bands, or while auto-trim is off.
- R6: A step that would take trim above 63 or below 0 leaves it at the bound and sets `flags[6]` (trim overflow).
- R7: Counting upward without a sync, the counter stops at limit × 128 and `flags[5]` (sync missed) is set. The next event captures the held value.
- R8: Prescaler code k passes every 2^k-th active edge (k = 0..7). The other edges cause no event.
- R9: Source code 0 selects `sync_pin`, 1 selects `sync_lsref`, and 2 or 3 selects `sync_sof`. Edges on unselected inputs have no effect. Polarity 1 makes falling edges active.
- R10: Writing control with bit2 set while counting is enabled produces a sync event in that cycle, the same as an input edge.
- R11: While count enable is 1, writes to the configuration register are ignored.
- R12: While auto-trim is on, the trim field of control writes is ignored.
- R13: Each clear bit resets its flag. The error-group bit clears `flags[4]`, `flags[5]` and `flags[6]` together.
- R14: `irq` is the OR of OK, warning, error and expected flags, each gated by its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin | input | 1 | Sync from an input pin |
| sync_lsref | input | 1 | Sync from a low-speed reference |
| sync_sof | input | 1 | Sync from a 1 kHz frame pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| trim_code | output | 6 | Oscillator trim code |
| err_cap | output | 16 | Error captured at the last sync event |
| err_dir | output | 1 | Direction captured at the last sync event |
| flags | output | 7 | {overflow, missed, sync error, expected, error, warning, OK} |
| irq | output | 1 | Combined interrupt |

## Verification
A table of period offsets, from zero through both sides of the limit and triple-limit boundaries, tells the three bands apart, the two directions apart, and warning steps from non-stepping cases. Directed patterns then use pulse pairs under the prescaler, where the odd pulse must leave the capture untouched, and a falling-edge pin with a toggling unselected line. A software sync fires at a chosen cycle, and a silence long enough to reach the missed-sync ceiling is followed by a late edge. Trim is pushed into both bounds to separate the saturating step from an ordinary one.

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter logic [15:0] RLD_RST  = 16'hBB7F,
  parameter logic [7:0]  LIM_RST  = 8'h22,
  parameter logic [5:0]  TRIM_RST = 6'd32,
  parameter int          MISS_SH  = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_pin,
  input  logic        sync_lsref,
  input  logic        sync_sof,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [5:0]  trim_code,
  output logic [15:0] err_cap,
  output logic        err_dir,
  output logic [6:0]  flags,
  output logic        irq
);
  localparam logic [5:0] TRIM_MAX = '1;

  logic        cnt_en, auto_en, pol;
  logic [3:0]  ie;
  logic [5:0]  trim;
  logic [15:0] reload, cnt, cap;
  logic [7:0]  lim;
  logic [2:0]  div;
  logic [1:0]  src;
  logic        sel_q, up, dir;
  logic [6:0]  pcnt;
  logic        f_ok, f_warn, f_exp, f_serr, f_miss, f_ovf;

  wire wr_ctrl = reg_we && reg_addr == 2'd0;
  wire wr_cfg  = reg_we && reg_addr == 2'd1;
  wire wr_clr  = reg_we && reg_addr == 2'd3;
  wire unused_bits = ^{reg_wdata[30], reg_wdata[27]};

  wire sel = (src == 2'd0) ? sync_pin : (src == 2'd1) ? sync_lsref : sync_sof;
  wire act_edge = pol ? (sel_q & ~sel) : (~sel_q & sel);
  wire [6:0] mask = 7'((8'd1 << div) - 8'd1);
  wire pre_hit = act_edge && ((pcnt & mask) == mask);
  wire ev = cnt_en && (pre_hit || (wr_ctrl && reg_wdata[2]));

  wire [15:0] miss_lim = 16'(lim) << MISS_SH;
  wire [9:0]  lim3     = {2'b0, lim} + {1'b0, lim, 1'b0};
  wire in_ok   = cnt < 16'(lim);
  wire in_warn = !in_ok && cnt < 16'(lim3);
  wire err_any = f_serr | f_miss | f_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en <= 1'b0; auto_en <= 1'b0; ie <= '0; trim <= TRIM_RST;
      reload <= RLD_RST; lim <= LIM_RST; div <= '0; src <= 2'd2; pol <= 1'b0;
      sel_q <= 1'b0; pcnt <= '0; cnt <= RLD_RST; up <= 1'b0;
      cap <= '0; dir <= 1'b0;
      f_ok <= 1'b0; f_warn <= 1'b0; f_exp <= 1'b0;
      f_serr <= 1'b0; f_miss <= 1'b0; f_ovf <= 1'b0;
    end else begin
      sel_q <= sel;
      if (!cnt_en)       pcnt <= '0;
      else if (act_edge) pcnt <= pcnt + 7'd1;

      if (wr_ctrl) begin
        cnt_en  <= reg_wdata[0];
        auto_en <= reg_wdata[1];
        ie      <= reg_wdata[6:3];
        if (!auto_en) trim <= reg_wdata[13:8];
      end
      if (wr_cfg && !cnt_en) begin
        reload <= reg_wdata[15:0];
        lim    <= reg_wdata[23:16];
        div    <= reg_wdata[26:24];
        src    <= reg_wdata[29:28];
        pol    <= reg_wdata[31];
      end
      if (wr_clr) begin
        if (reg_wdata[0]) f_ok   <= 1'b0;
        if (reg_wdata[1]) f_warn <= 1'b0;
        if (reg_wdata[2]) begin f_serr <= 1'b0; f_miss <= 1'b0; f_ovf <= 1'b0; end
        if (reg_wdata[3]) f_exp  <= 1'b0;
      end

      if (!cnt_en) begin
        cnt <= reload;
        up  <= 1'b0;
      end else if (ev) begin
        cnt <= reload;
        up  <= 1'b0;
        cap <= cnt;
        dir <= ~up;
        if (in_ok) f_ok <= 1'b1;
        else if (in_warn) begin
          f_warn <= 1'b1;
          if (auto_en) begin
            if (!up) begin
              if (trim == TRIM_MAX) f_ovf <= 1'b1;
              else trim <= trim + 6'd1;
            end else begin
              if (trim == '0) f_ovf <= 1'b1;
              else trim <= trim - 6'd1;
            end
          end
        end else f_serr <= 1'b1;
      end else if (!up) begin
        if (cnt == '0) begin
          up  <= 1'b1;
          cnt <= 16'd1;
        end else begin
          cnt <= cnt - 16'd1;
          if (cnt == 16'd1) f_exp <= 1'b1;
        end
      end else if (cnt >= miss_lim) f_miss <= 1'b1;
      else cnt <= cnt + 16'd1;
    end
  end

  assign trim_code = trim;
  assign err_cap   = cap;
  assign err_dir   = dir;
  assign flags     = {f_ovf, f_miss, f_serr, f_exp, err_any, f_warn, f_ok};
  assign irq       = |(ie & {f_exp, err_any, f_warn, f_ok});

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {18'd0, trim, 1'b0, ie, 1'b0, auto_en, cnt_en};
      2'd1:    reg_rdata = {pol, 1'b0, src, 1'b0, div, lim, reload};
      2'd2:    reg_rdata = {cap, dir, 8'd0, flags};
      default: reg_rdata = {31'd0, unused_bits & 1'b0};
    endcase
  end

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && cnt_en) |=> ($stable(reload) && $stable(lim) && $stable(div)));

  // R12
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !ev) |=> $stable(trim));

  // R6
  ovf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ovf) |-> (trim == '0 || trim == TRIM_MAX));

  // R3
  exp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ev && !up && cnt == 16'd1) |=> f_exp);

  // R7
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ev && up && cnt >= miss_lim) |=> ($stable(cnt) && f_miss));
endmodule

// File: tb/tb_osc_trim_ctrl.sv
module tb_osc_trim_ctrl;
  logic clk = 0, rst_n = 0;
  logic sync_pin = 0, sync_lsref = 0, sync_sof = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [5:0] trim_code;
  logic [15:0] err_cap;
  logic err_dir, irq;
  logic [6:0] flags;

  osc_trim_ctrl dut (.clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .sync_lsref(sync_lsref),
    .sync_sof(sync_sof), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trim_code(trim_code), .err_cap(err_cap), .err_dir(err_dir),
    .flags(flags), .irq(irq));

  always #2 clk = ~clk;

  localparam int RLD = 99;
  localparam int LIM = 4;
  localparam int VEC_N = 12;
  localparam int VEC_D [VEC_N] = '{0, 2, -3, 3, 4, -4, 5, -7, 11, 12, -12, -11};

  int n_cmp = 0, n_bad = 0, used = 0, model_trim = 32, cur_src = 2;
  logic cur_pol = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_w(bit en, bit au, bit sw, logic [3:0] ie, int tr);
    return {18'd0, 6'(tr), 1'b0, ie, sw, au, en};
  endfunction

  function automatic logic [31:0] cfg_w(logic [15:0] r, logic [7:0] l, logic [2:0] d,
                                        logic [1:0] s, bit p);
    return {p, 1'b0, s, 1'b0, d, l, r};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    used++;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    used += n;
  endtask

  task automatic set_line(logic v);
    case (cur_src)
      0: sync_pin = v;
      1: sync_lsref = v;
      default: sync_sof = v;
    endcase
  endtask

  task automatic sync_gap(int g);
    repeat (g - 1) @(negedge clk);
    set_line(~cur_pol);
    @(negedge clk);
    set_line(cur_pol);
    used = 0;
  endtask

  task automatic run(int d);
    wr(2'd3, 32'hF);
    sync_gap(RLD + 1 + d - used);
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), int'(exp));
    reg_addr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 trim", trim_code, 32);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    rd_chk("R1 cfg", 2'd1, cfg_w(16'hBB7F, 8'h22, 3'd0, 2'd2, 1'b0));
    rd_chk("R1 ctrl", 2'd0, 32'h2000);

    wr(2'd1, cfg_w(16'(RLD), 8'(LIM), 3'd0, 2'd2, 1'b0));
    wr(2'd0, ctrl_w(1, 1, 0, 4'd0, 32));
    sync_gap(RLD + 1);
    chk("R2 prime cap", err_cap, 0);
    chk("R4 prime ok", flags[0], 1);

    for (int i = 0; i < VEC_N; i++) begin
      int d, mag, band;
      d = VEC_D[i];
      mag = (d < 0) ? -d : d;
      band = (mag < LIM) ? 0 : (mag < 3 * LIM) ? 1 : 2;
      if (band == 1) model_trim += (d > 0) ? -1 : 1;
      run(d);
      chk("R2 capture", err_cap, mag);
      chk("R2 direction", err_dir, (d > 0) ? 0 : 1);
      chk("R4 ok band", flags[0], band == 0);
      chk("R4 warn band", flags[1], band == 1);
      chk("R4 sync error", flags[4], band == 2);
      chk("R4 error or", flags[2], band == 2);
      chk("R3 expected", flags[3], d >= 0);
      chk("R5 trim step", trim_code, model_trim);
    end

    wr(2'd0, ctrl_w(1, 1, 0, 4'd0, 5));
    chk("R12 trim write ignored", trim_code, model_trim);
    wr(2'd1, cfg_w(16'h1234, 8'h77, 3'd3, 2'd0, 1'b1));
    rd_chk("R11 cfg locked", 2'd1, cfg_w(16'(RLD), 8'(LIM), 3'd0, 2'd2, 1'b0));
    run(0);
    chk("R11 reload kept", err_cap, 0);

    chk("R14 no enables", irq, 0);
    wr(2'd0, ctrl_w(1, 1, 0, 4'b0010, 0));
    chk("R14 ok not enabled", irq, 0);
    run(6);
    model_trim -= 1;
    chk("R14 warn irq", irq, 1);
    chk("R5 fast step down", trim_code, model_trim);
    wr(2'd3, 32'h2);
    chk("R13 warn cleared", flags[1], 0);
    chk("R14 irq drops", irq, 0);

    wr(2'd0, ctrl_w(1, 0, 0, 4'd0, 62));
    wr(2'd0, ctrl_w(1, 1, 0, 4'd0, 62));
    model_trim = 62;
    run(-5);
    chk("R6 step to top", trim_code, 63);
    chk("R6 no ovf yet", flags[6], 0);
    run(-5);
    chk("R6 top held", trim_code, 63);
    chk("R6 ovf flag", flags[6], 1);
    chk("R6 error or", flags[2], 1);
    wr(2'd3, 32'h4);
    chk("R13 error group cleared", flags[6:4], 0);
    chk("R13 err cleared", flags[2], 0);
    chk("R13 warn kept", flags[1], 1);
    wr(2'd0, ctrl_w(1, 0, 0, 4'd0, 1));
    wr(2'd0, ctrl_w(1, 1, 0, 4'd0, 1));
    run(5);
    chk("R6 step to bottom", trim_code, 0);
    run(5);
    chk("R6 bottom held", trim_code, 0);
    chk("R6 ovf low", flags[6], 1);
    model_trim = 0;

    wr(2'd3, 32'hF);
    idle(RLD + 1 + 520);
    chk("R7 missed flag", flags[5], 1);
    chk("R7 error or", flags[2], 1);
    sync_gap(5);
    chk("R7 held capture", err_cap, LIM * 128);
    chk("R7 direction", err_dir, 0);
    chk("R7 sync error", flags[4], 1);

    wr(2'd3, 32'hF);
    idle(RLD + 2 - used);
    wr(2'd0, ctrl_w(1, 1, 1, 4'd0, 0));
    used = 0;
    chk("R10 software capture", err_cap, 2);
    chk("R10 direction", err_dir, 0);
    chk("R10 ok", flags[0], 1);

    wr(2'd0, ctrl_w(1, 0, 0, 4'd0, 0));
    wr(2'd0, ctrl_w(0, 0, 0, 4'd0, 0));
    wr(2'd1, cfg_w(16'(RLD), 8'(LIM), 3'd1, 2'd2, 1'b0));
    wr(2'd0, ctrl_w(1, 0, 0, 4'd0, 0));
    sync_gap(50);
    sync_gap(RLD + 1 - 50);
    chk("R8 divided prime", err_cap, 0);
    sync_gap(40);
    chk("R8 odd edge ignored", err_cap, 0);
    sync_gap(RLD + 1 + 6 - 40);
    chk("R8 divided capture", err_cap, 6);
    chk("R8 warn", flags[1], 1);
    chk("R5 auto off holds trim", trim_code, model_trim);

    wr(2'd0, ctrl_w(0, 0, 0, 4'd0, 0));
    sync_pin = 1;
    wr(2'd1, cfg_w(16'(RLD), 8'(LIM), 3'd0, 2'd0, 1'b1));
    cur_src = 0;
    cur_pol = 1;
    wr(2'd0, ctrl_w(1, 0, 0, 4'd0, 0));
    sync_gap(RLD + 1);
    chk("R9 pin prime", err_cap, 0);
    sync_sof = 1;
    run(-8);
    sync_sof = 0;
    chk("R9 falling pin capture", err_cap, 8);
    chk("R9 direction", err_dir, 1);
    chk("R9 warn", flags[1], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule